// File: doc/BRIEF.md
# Bipolar Coincidence Trigger

This block watches a bank of channels. Each channel has two digitised discriminator bits, one for a positive threshold and one for a negative threshold. In coincidence mode a channel raises its trigger only when a positive and a negative crossing both arrive within a programmable number of clock cycles of each other, in either order. This picks out short bipolar impulses and rejects crossings of one polarity alone. Every crossing opens a window: a rising edge on a discriminator bit loads a down-counter with the window length. A trigger fires when a new crossing arrives while the window of the other polarity is still open, or when both polarities rise in the same cycle.

In direct mode the coincidence logic is held idle. The registered discriminator bits appear on the monitor outputs so that thresholds and rates can be observed. In both modes, per-channel saturating counters tally rising edges of each polarity for rate control. Channels share only the window length and the mode select, and each channel's trigger depends on nothing else from the other channels.

Top module: `bipolar_trigger`

## Requirements
- R1: While reset is held and on the first cycle after its release, `trigOut`, `monHi`, `monLo`, `hiCount` and `loCount` are all zero.
- R2: In coincidence mode with window length W > 0, a positive rising edge in cycle n followed by a negative rising edge in cycle n+k, with 1 <= k <= W, raises that channel's `trigOut` for exactly one cycle, in cycle n+k+1.
- R3: The order of the two crossings does not matter: a negative edge followed within W cycles by a positive edge fires in the same way, and edges of both polarities in the same cycle n fire in cycle n+1.
- R4: Two crossings of opposite polarity that are more than W cycles apart do not fire a trigger.
- R5: Crossings of one polarity alone never fire, whether they are repeated pulses or a level held high.
- R6: With a window length of zero, no trigger fires.
- R7: When a trigger fires, both windows of that channel close. A further crossing that would have paired with the crossings already used does not fire a second trigger.
- R8: Each channel pairs only its own two bits. A positive crossing on one channel and a negative crossing on another never fire, and a bipolar event on one channel does not fire its neighbours.
- R9: With `directMode` = 1, `monHi` and `monLo` show the discriminator inputs one cycle later and `trigOut` stays zero. With `directMode` = 0, `monHi` and `monLo` are zero.
- R10: Channel c's counters sit at bits [c*CNT_W +: CNT_W] of `hiCount` and `loCount`. Each counter adds one per rising edge of its bit in either mode, visible the next cycle. A held level counts once, and a counter stops at all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hiCmp | input | NUM_CH | Positive-threshold discriminator bit per channel |
| loCmp | input | NUM_CH | Negative-threshold discriminator bit per channel |
| winLen | input | WIN_W | Coincidence window length in cycles; 0 disables triggering |
| directMode | input | 1 | 1 = raw discriminator bits to monitors, 0 = coincidence triggering |
| trigOut | output | NUM_CH | One-cycle trigger per channel |
| monHi | output | NUM_CH | Registered positive bits in direct mode, else zero |
| monLo | output | NUM_CH | Registered negative bits in direct mode, else zero |
| hiCount | output | NUM_CH*CNT_W | Saturating positive-crossing counters, channel c at [c*CNT_W +: CNT_W] |
| loCount | output | NUM_CH*CNT_W | Saturating negative-crossing counters, channel c at [c*CNT_W +: CNT_W] |

## Verification
Pairs of crossings are placed at separations of 3, W and W+1 cycles. This separates an inclusive window edge from one that is off by one. Reversed order and same-cycle arrival show that either polarity can open the window. Trains of one-polarity pulses and held levels show that a single sign never fires. A re-crossing right after a trigger shows that the windows are cleared. Split-channel patterns show that channels do not pair with each other. Direct-mode stretches and a long pulse train confirm the monitor path and the counter saturation.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic hiCross;  // positive rising edge, for rate counting
    logic loCross;  // negative rising edge, for rate counting
    logic hiOpen;   // load positive window
    logic loOpen;   // load negative window
    logic clear;    // close both windows
  } chStrobe_t;
endpackage

// File: rtl/window_stretch.sv
module window_stretch #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             open,
  input  logic             clear,
  input  logic [WIN_W-1:0] len,
  output logic             active
);
  logic [WIN_W-1:0] left;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              left <= '0;
    else if (clear)         left <= '0;
    else if (open)          left <= len;
    else if (left != '0)    left <= left - 1'b1;
  end

  assign active = (left != '0);

  // R7
  clear_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !active);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          value <= '0;
    else if (inc && value != CntMax)    value <= value + 1'b1;
  end

  // R10
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (value == CntMax) |=> (value == CntMax));
  // R10
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    value >= $past(value));
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        hiCmp,
  input  logic [NUM_CH-1:0]        loCmp,
  input  logic                     directMode,
  input  logic                     winZero,
  input  logic [NUM_CH-1:0]        hiActive,
  input  logic [NUM_CH-1:0]        loActive,
  output chStrobe_t [NUM_CH-1:0]   strobes,
  output logic [NUM_CH-1:0]        trigOut,
  output logic [NUM_CH-1:0]        monHi,
  output logic [NUM_CH-1:0]        monLo
);
  logic [NUM_CH-1:0] hiPrev, loPrev, hiEdge, loEdge, fire;
  logic armed;

  assign armed  = !directMode && !winZero;
  assign hiEdge = hiCmp & ~hiPrev;
  assign loEdge = loCmp & ~loPrev;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign fire[ch] = armed && (hiEdge[ch] || hiActive[ch])
                            && (loEdge[ch] || loActive[ch]);
    assign strobes[ch] = '{hiCross: hiEdge[ch],
                           loCross: loEdge[ch],
                           hiOpen:  armed && hiEdge[ch],
                           loOpen:  armed && loEdge[ch],
                           clear:   fire[ch] || !armed};

    // R2
    trig_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      trigOut[ch] |=> !trigOut[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiPrev  <= '0;
      loPrev  <= '0;
      trigOut <= '0;
      monHi   <= '0;
      monLo   <= '0;
    end else begin
      hiPrev  <= hiCmp;
      loPrev  <= loCmp;
      trigOut <= fire;
      monHi   <= directMode ? hiCmp : '0;
      monLo   <= directMode ? loCmp : '0;
    end
  end

  // R9
  direct_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(directMode) |-> (trigOut == '0));
  // R6
  winzero_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(winZero) |-> (trigOut == '0));
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WIN_W-1:0]          winLen,
  input  chStrobe_t [NUM_CH-1:0]    strobes,
  output logic [NUM_CH-1:0]         hiActive,
  output logic [NUM_CH-1:0]         loActive,
  output logic [NUM_CH*CNT_W-1:0]   hiCount,
  output logic [NUM_CH*CNT_W-1:0]   loCount
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    window_stretch #(.WIN_W(WIN_W)) u_hiWin (
      .clk(clk), .rstN(rstN), .open(strobes[ch].hiOpen),
      .clear(strobes[ch].clear), .len(winLen), .active(hiActive[ch]));
    window_stretch #(.WIN_W(WIN_W)) u_loWin (
      .clk(clk), .rstN(rstN), .open(strobes[ch].loOpen),
      .clear(strobes[ch].clear), .len(winLen), .active(loActive[ch]));
    sat_counter #(.CNT_W(CNT_W)) u_hiCnt (
      .clk(clk), .rstN(rstN), .inc(strobes[ch].hiCross),
      .value(hiCount[ch*CNT_W +: CNT_W]));
    sat_counter #(.CNT_W(CNT_W)) u_loCnt (
      .clk(clk), .rstN(rstN), .inc(strobes[ch].loCross),
      .value(loCount[ch*CNT_W +: CNT_W]));
  end
endmodule

// File: rtl/bipolar_trigger.sv
module bipolar_trigger
  import trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       hiCmp,
  input  logic [NUM_CH-1:0]       loCmp,
  input  logic [WIN_W-1:0]        winLen,
  input  logic                    directMode,
  output logic [NUM_CH-1:0]       trigOut,
  output logic [NUM_CH-1:0]       monHi,
  output logic [NUM_CH-1:0]       monLo,
  output logic [NUM_CH*CNT_W-1:0] hiCount,
  output logic [NUM_CH*CNT_W-1:0] loCount
);
  chStrobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH-1:0] hiActive, loActive;
  logic winZero;

  assign winZero = (winLen == '0);

  trig_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hiCmp(hiCmp), .loCmp(loCmp),
    .directMode(directMode), .winZero(winZero),
    .hiActive(hiActive), .loActive(loActive), .strobes(strobes),
    .trigOut(trigOut), .monHi(monHi), .monLo(monLo));

  trig_datapath #(.NUM_CH(NUM_CH), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .winLen(winLen), .strobes(strobes),
    .hiActive(hiActive), .loActive(loActive),
    .hiCount(hiCount), .loCount(loCount));
endmodule

// File: tb/sim_bipolar_trigger.sv
module sim_bipolar_trigger;
  localparam int NCH = 4;
  localparam int WW  = 8;
  localparam int CW  = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] hiCmp = '0;
  logic [NCH-1:0] loCmp = '0;
  logic [WW-1:0] winLen = 8'd5;
  logic directMode = 1'b0;
  logic [NCH-1:0] trigOut, monHi, monLo;
  logic [NCH*CW-1:0] hiCount, loCount;

  always #4 clk = ~clk;  // 125 MHz

  bipolar_trigger #(.NUM_CH(NCH), .WIN_W(WW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .hiCmp(hiCmp), .loCmp(loCmp), .winLen(winLen),
    .directMode(directMode), .trigOut(trigOut), .monHi(monHi), .monLo(monLo),
    .hiCount(hiCount), .loCount(loCount));

  typedef struct {
    int cyc;
    logic [NCH-1:0] mask;
    string req;
  } expItem_t;

  expItem_t q[$];
  int cyc = 0;
  int nCmp = 0;
  int nBad = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";
  int expHi[NCH];
  int expLo[NCH];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares trigOut against scoreboard every cycle
  always @(negedge clk) begin
    logic [NCH-1:0] e;
    string r;
    if (monOn && !done) begin
      e = '0;
      r = curReq;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        if (q[0].cyc == cyc) begin
          e = e | q[0].mask;
          r = q[0].req;
        end
        void'(q.pop_front());
      end
      nCmp++;
      if (trigOut !== e) begin
        nBad++;
        $display("FAIL %s trigOut actual=%b expected=%b cycle %0d", r, trigOut, e, cyc);
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp, input string what);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes expected triggers
  task automatic step(input logic [NCH-1:0] h, input logic [NCH-1:0] l,
                      input logic [NCH-1:0] m, input string r);
    for (int c = 0; c < NCH; c++) begin
      if (h[c] && !hiCmp[c] && expHi[c] < CMAX) expHi[c]++;
      if (l[c] && !loCmp[c] && expLo[c] < CMAX) expLo[c]++;
    end
    hiCmp = h;
    loCmp = l;
    if (m != '0) q.push_back('{cyc + 1, m, r});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, '0, curReq);
  endtask

  task automatic chkCounts(input string r);
    for (int c = 0; c < NCH; c++) begin
      chk(r, int'(hiCount[c*CW +: CW]), expHi[c], $sformatf("hiCount[%0d]", c));
      chk(r, int'(loCount[c*CW +: CW]), expLo[c], $sformatf("loCount[%0d]", c));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin expHi[c] = 0; expLo[c] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk("R1", int'(trigOut), 0, "trigOut in reset");
    chk("R1", int'(hiCount), 0, "hiCount in reset");
    rstN = 1'b1;
    @(negedge clk);
    // R1: first cycle after release
    chk("R1", int'(trigOut), 0, "trigOut");
    chk("R1", int'(monHi), 0, "monHi");
    chk("R1", int'(monLo), 0, "monLo");
    chkCounts("R1");
    monOn = 1'b1;

    // R2: hi then lo, separation 3
    curReq = "R2";
    step(4'b0001, '0, '0, "R2"); idle(2);
    step('0, 4'b0001, 4'b0001, "R2"); idle(8);
    // R2: separation exactly W
    step(4'b0001, '0, '0, "R2"); idle(4);
    step('0, 4'b0001, 4'b0001, "R2"); idle(8);

    // R4: separation W+1
    curReq = "R4";
    step(4'b0001, '0, '0, "R4"); idle(5);
    step('0, 4'b0001, '0, "R4"); idle(8);

    // R3: lo first then hi at W, and same-cycle arrival
    curReq = "R3";
    step('0, 4'b0010, '0, "R3"); idle(4);
    step(4'b0010, '0, 4'b0010, "R3"); idle(8);
    step(4'b0100, 4'b0100, 4'b0100, "R3"); idle(8);

    // R5: one polarity only, pulses then held level
    curReq = "R5";
    for (int i = 0; i < 6; i++) begin step(4'b1000, '0, '0, "R5"); idle(1); end
    for (int i = 0; i < 4; i++) step(4'b1000, '0, '0, "R5");
    idle(8);
    for (int i = 0; i < 3; i++) begin step('0, 4'b0100, '0, "R5"); idle(1); end
    idle(8);
    // R10: held level counted once
    chkCounts("R10");

    // R6: zero window
    curReq = "R6";
    winLen = '0;
    step(4'b0001, '0, '0, "R6");
    step('0, 4'b0001, '0, "R6");
    step(4'b0010, 4'b0010, '0, "R6"); idle(8);
    winLen = 8'd5;

    // R7: windows close after a trigger
    curReq = "R7";
    step(4'b0001, '0, '0, "R7");
    step('0, 4'b0001, 4'b0001, "R7");
    idle(1);
    step(4'b0001, '0, '0, "R7"); idle(8);

    // R8: channels do not pair across
    curReq = "R8";
    step(4'b0001, 4'b0010, '0, "R8"); idle(8);
    step(4'b0011, '0, '0, "R8");
    step('0, 4'b0001, 4'b0001, "R8"); idle(8);

    // R9: direct mode
    curReq = "R9";
    directMode = 1'b1;
    step(4'b1010, 4'b0110, '0, "R9");
    chk("R9", int'(monHi), 4'b1010, "monHi direct");
    chk("R9", int'(monLo), 4'b0110, "monLo direct");
    step(4'b0001, 4'b0001, '0, "R9");
    chk("R9", int'(monHi), 4'b0001, "monHi direct");
    chk("R9", int'(monLo), 4'b0001, "monLo direct");
    idle(1);
    directMode = 1'b0;
    step(4'b0110, 4'b1001, '0, "R9");
    chk("R9", int'(monHi), 0, "monHi coincidence mode");
    chk("R9", int'(monLo), 0, "monLo coincidence mode");
    idle(8);
    chkCounts("R10");

    // R10: saturation on ch3 negative counter
    curReq = "R10";
    for (int i = 0; i < 20; i++) begin step('0, 4'b1000, '0, "R10"); idle(1); end
    chk("R10", int'(loCount[3*CW +: CW]), CMAX, "loCount[3] saturated");
    chkCounts("R10");
    idle(4);

    summary();
  end
endmodule